// File: doc/BRIEF.md
# PLL Output Frequency Calculator

This block works out the output frequency, in kHz, of a clock synthesizer from a snapshot of that synthesizer's settings. A host pulses `start_i` and presents a 32-bit control word, a 32-bit coefficient word and a 2-bit source select in the same cycle. The block captures them and decodes the enable, the gating bits, the post-divider exponent and the multiplier/divider pairs. It then evaluates one or two multiply-then-divide stages on a shared restoring divider. When the frequency is ready it raises `done_o` for one cycle.

The source select sets the register layout. A value of 3 means the two-stage synthesizer, whose coefficients are held in the coefficient word. A value of 2 means the single-stage synthesizer, whose coefficients sit in the control word. Any other value gives zero. Every illegal or disabled setting also gives zero and never divides by zero. The block only evaluates settings: it neither searches for coefficients nor writes any back.

Top module: `pll_freq_calc`

## Requirements
- R1: A synchronous active-low reset clears `busy_o`, `done_o` and `freq_khz_o` to zero.
- R2: With source select 2, the result is 27000*N/M, where N is control bits 15:8 and M is control bits 7:0. The coefficient word has no effect in this mode.
- R3: With source select 3, the first stage is 27000*N1/M1, where N1 is coefficient bits 15:8 and M1 is coefficient bits 7:0. The control bits 15:0 are not used as coefficients.
- R4: With source select 3, the stage-one value is multiplied by N2 (coefficient bits 31:24) and divided by M2 (coefficient bits 23:16) only when control bit 30 is 1 and control bit 8 is 0. Otherwise stage one is the whole result.
- R5: The value is shifted right by P, the unsigned number in control bits 18:16, after all divisions.
- R6: When control bit 31 is 0, the result is 0.
- R7: A zero M (source 2), a zero M1, or a zero M2 while the second stage is active, each gives a result of 0.
- R8: A source select of 0 or 1 gives a result of 0.
- R9: `done_o` is high for exactly one cycle, with `busy_o` low, when a new result appears. `freq_khz_o` changes only in that cycle and holds otherwise.
- R10: A start is taken only while `busy_o` is low, which includes the cycle in which `done_o` is high. A start while busy changes neither the inputs captured nor the result.
- R11: Each stage multiplies first and then divides, with truncation toward zero. Intermediate values are kept at 40 bits, so the largest legal settings do not overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request to evaluate the inputs presented in this cycle |
| src_sel_i | input | 2 | Source select: 3 two-stage, 2 single-stage, else zero |
| ctrl_i | input | 32 | Control word snapshot |
| coef_i | input | 32 | Coefficient word snapshot |
| busy_o | output | 1 | An evaluation is in progress |
| done_o | output | 1 | One-cycle strobe: `freq_khz_o` has just been updated |
| freq_khz_o | output | 32 | Computed frequency in kHz |

## Verification
The completion of one evaluation and the acceptance of the next can happen in the same cycle. The bench provokes this by raising `start_i` in the very cycle `done_o` is sampled high. It then checks three things: the block goes busy, the old frequency holds on the output until the next strobe, and the second result belongs to the second request. A second case raises a start with different settings in the middle of a run. The result that then arrives must be the first request's, and no extra strobe may follow.

// File: rtl/pll_calc_pkg.sv
// Package: shared state type and source-select codes for the PLL frequency calculator.
// Assumes: a 2-bit source select.
package pll_calc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EVAL = 2'd1,
        ST_DIV1 = 2'd2,
        ST_DIV2 = 2'd3
    } calc_state_e;

    localparam logic [1:0] SRC_SINGLE = 2'd2;
    localparam logic [1:0] SRC_DUAL   = 2'd3;
endpackage

// File: rtl/pll_field_decode.sv
// Module: pll_field_decode
// Splits the captured control and coefficient words into the operands of each
// stage, the post-divider exponent, the stage-two gate and a validity flag.
// The validity flag covers the enable bit, the source select and a zero
// first-stage divider.
// Assumes: the top two bits of the control word are enable and stage-two gate,
// and the gate-cancel bit sits right above the first coefficient byte.
module pll_field_decode
    import pll_calc_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int COEF_W = 8,
    parameter int P_W    = 3,
    parameter int P_LSB  = 16
) (
    input  logic [WORD_W-1:0] ctrl_i,
    input  logic [WORD_W-1:0] coef_i,
    input  logic [1:0]        src_i,
    output logic              valid_o,
    output logic              stage2_o,
    output logic [COEF_W-1:0] n1_o,
    output logic [COEF_W-1:0] m1_o,
    output logic [COEF_W-1:0] n2_o,
    output logic [COEF_W-1:0] m2_o,
    output logic [P_W-1:0]    p_o
);
    localparam int EN_BIT     = WORD_W - 1;
    localparam int GATE_BIT   = WORD_W - 2;
    localparam int CANCEL_BIT = COEF_W;

    logic is_single;
    logic is_dual;

    // Operand selection by layout.
    always_comb begin
        is_single = (src_i == SRC_SINGLE);
        is_dual   = (src_i == SRC_DUAL);
        p_o       = ctrl_i[P_LSB +: P_W];
        n2_o      = coef_i[3*COEF_W +: COEF_W];
        m2_o      = coef_i[2*COEF_W +: COEF_W];
        if (is_dual) begin
            n1_o = coef_i[COEF_W +: COEF_W];
            m1_o = coef_i[0 +: COEF_W];
        end else begin
            n1_o = ctrl_i[COEF_W +: COEF_W];
            m1_o = ctrl_i[0 +: COEF_W];
        end
        valid_o  = ctrl_i[EN_BIT] && (is_single || is_dual) && (m1_o != '0);
        stage2_o = is_dual && ctrl_i[GATE_BIT] && !ctrl_i[CANCEL_BIT];
    end
endmodule

// File: rtl/pll_divider.sv
// Module: pll_divider
// Restoring shift-subtract unsigned divider. It takes one quotient bit per
// cycle and pulses done_o once, DVD_W cycles after a start is accepted.
// Assumes: the divisor is nonzero and start_i is raised only while idle.
module pll_divider #(
    parameter int DVD_W = 40,
    parameter int DVS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [DVD_W-1:0] dividend_i,
    input  logic [DVS_W-1:0] divisor_i,
    output logic             done_o,
    output logic [DVD_W-1:0] quot_o
);
    localparam int CNT_W = $clog2(DVD_W + 1);

    logic [DVS_W:0]   rem_q;
    logic [DVD_W-1:0] quo_q;
    logic [DVS_W-1:0] dvs_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic [DVS_W:0]   shifted;
    logic             fits;

    // One restoring step: bring in the next dividend bit and try the subtraction.
    always_comb begin
        shifted = {rem_q[DVS_W-1:0], quo_q[DVD_W-1]};
        fits    = (shifted >= {1'b0, dvs_q});
    end

    // Iteration registers and the completion strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quo_q  <= '0;
            dvs_q  <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (start_i && !run_q) begin
                quo_q <= dividend_i;
                rem_q <= '0;
                dvs_q <= divisor_i;
                cnt_q <= '0;
                run_q <= 1'b1;
            end else if (run_q) begin
                quo_q <= {quo_q[DVD_W-2:0], fits};
                rem_q <= fits ? (shifted - {1'b0, dvs_q}) : shifted;
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == CNT_W'(DVD_W - 1)) begin
                    run_q  <= 1'b0;
                    done_o <= 1'b1;
                end
            end
        end
    end

    assign quot_o = quo_q;
endmodule

// File: rtl/pll_freq_calc.sv
// Module: pll_freq_calc (top)
// Captures a settings snapshot on start and evaluates reference*N1/M1. When the
// stage-two gate is active it then applies *N2/M2. The value is shifted right
// by P and returned with a one-cycle done strobe. Disabled or illegal settings
// give zero without using the divider.
// Assumes: REF_KHZ*(2^COEF_W-1)^2 fits in PROD_W bits.
module pll_freq_calc
    import pll_calc_pkg::*;
#(
    parameter int REF_KHZ = 27000,
    parameter int WORD_W  = 32,
    parameter int COEF_W  = 8,
    parameter int P_W     = 3,
    parameter int PROD_W  = 40,
    parameter int FREQ_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        src_sel_i,
    input  logic [WORD_W-1:0] ctrl_i,
    input  logic [WORD_W-1:0] coef_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [FREQ_W-1:0] freq_khz_o
);
    localparam int EXT_W = PROD_W - COEF_W;
    localparam logic [PROD_W-1:0] REF_W = PROD_W'(REF_KHZ);

    calc_state_e       state_q;
    logic [WORD_W-1:0] ctrl_q;
    logic [WORD_W-1:0] coef_q;
    logic [1:0]        src_q;

    logic              valid;
    logic              stage2;
    logic [COEF_W-1:0] n1, m1, n2, m2;
    logic [P_W-1:0]    p;

    logic              div_start;
    logic              div_done;
    logic [PROD_W-1:0] div_dividend;
    logic [COEF_W-1:0] div_divisor;
    logic [PROD_W-1:0] div_quot;
    logic [PROD_W-1:0] shifted_q;

    pll_field_decode #(
        .WORD_W (WORD_W),
        .COEF_W (COEF_W),
        .P_W    (P_W)
    ) u_decode (
        .ctrl_i   (ctrl_q),
        .coef_i   (coef_q),
        .src_i    (src_q),
        .valid_o  (valid),
        .stage2_o (stage2),
        .n1_o     (n1),
        .m1_o     (m1),
        .n2_o     (n2),
        .m2_o     (m2),
        .p_o      (p)
    );

    // Divider launch and operand steering for both stages.
    always_comb begin
        div_start    = 1'b0;
        div_dividend = REF_W * {{EXT_W{1'b0}}, n1};
        div_divisor  = m1;
        if (state_q == ST_EVAL) begin
            div_start = valid;
        end else begin
            div_dividend = div_quot * {{EXT_W{1'b0}}, n2};
            div_divisor  = m2;
            div_start    = (state_q == ST_DIV1) && div_done && stage2 && (m2 != '0);
        end
        shifted_q = div_quot >> p;
    end

    pll_divider #(
        .DVD_W (PROD_W),
        .DVS_W (COEF_W)
    ) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (div_start),
        .dividend_i (div_dividend),
        .divisor_i  (div_divisor),
        .done_o     (div_done),
        .quot_o     (div_quot)
    );

    // Sequencer: capture, stage selection, result and strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            ctrl_q     <= '0;
            coef_q     <= '0;
            src_q      <= '0;
            busy_o     <= 1'b0;
            done_o     <= 1'b0;
            freq_khz_o <= '0;
        end else begin
            done_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        ctrl_q  <= ctrl_i;
                        coef_q  <= coef_i;
                        src_q   <= src_sel_i;
                        busy_o  <= 1'b1;
                        state_q <= ST_EVAL;
                    end
                end
                ST_EVAL: begin
                    if (!valid) begin
                        freq_khz_o <= '0;
                        done_o     <= 1'b1;
                        busy_o     <= 1'b0;
                        state_q    <= ST_IDLE;
                    end else begin
                        state_q <= ST_DIV1;
                    end
                end
                ST_DIV1: begin
                    if (div_done) begin
                        if (stage2 && (m2 != '0)) begin
                            state_q <= ST_DIV2;
                        end else begin
                            freq_khz_o <= stage2 ? '0 : FREQ_W'(shifted_q);
                            done_o     <= 1'b1;
                            busy_o     <= 1'b0;
                            state_q    <= ST_IDLE;
                        end
                    end
                end
                ST_DIV2: begin
                    if (div_done) begin
                        freq_khz_o <= FREQ_W'(shifted_q);
                        done_o     <= 1'b1;
                        busy_o     <= 1'b0;
                        state_q    <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pll_freq_calc_chk.sv
// Module: pll_freq_calc_chk
// Checker for the handshake and output-hold rules of pll_freq_calc. It is
// bound to the top module.
// Assumes: the reset is synchronous and active low.
module pll_freq_calc_chk #(
    parameter int FREQ_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [FREQ_W-1:0] freq_khz_o
);
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!busy_o && !done_o && (freq_khz_o == '0)));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(freq_khz_o));

    assert_start_taken_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    assert_busy_ends_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (busy_o || done_o));
endmodule

bind pll_freq_calc pll_freq_calc_chk #(.FREQ_W(FREQ_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .freq_khz_o (freq_khz_o)
);

// File: tb/tb_pll_freq_calc.sv
// Bench for pll_freq_calc: a vector table walked by one loop, then directed
// tests of reset, a start while busy, a start in the done cycle, and a reset
// in the middle of a run.
module tb_pll_freq_calc;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 15;
    localparam int WD_LIMIT   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  src_sel_i = '0;
    logic [31:0] ctrl_i = '0;
    logic [31:0] coef_i = '0;
    logic        busy_o;
    logic        done_o;
    logic [31:0] freq_khz_o;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    // {tag id, src, ctrl, coef, expected}
    localparam logic [101:0] VEC [0:NVEC-1] = '{
        {4'd2,  2'd2, 32'h80000A01, 32'hFFFFFFFF, 32'd270000},
        {4'd5,  2'd2, 32'h80026403, 32'hFFFFFFFF, 32'd225000},
        {4'd6,  2'd2, 32'h00006403, 32'h00000000, 32'd0},
        {4'd7,  2'd2, 32'h80006400, 32'h00000000, 32'd0},
        {4'd3,  2'd3, 32'h80000055, 32'h02011403, 32'd180000},
        {4'd4,  2'd3, 32'hC0000000, 32'h02011403, 32'd360000},
        {4'd4,  2'd3, 32'hC0000100, 32'h02011403, 32'd180000},
        {4'd11, 2'd3, 32'hC0010000, 32'h07053207, 32'd134999},
        {4'd7,  2'd3, 32'hC0000000, 32'h05001403, 32'd0},
        {4'd7,  2'd3, 32'h80000000, 32'h02011400, 32'd0},
        {4'd8,  2'd1, 32'h80000A01, 32'h00000000, 32'd0},
        {4'd8,  2'd0, 32'h80000A01, 32'h00000000, 32'd0},
        {4'd6,  2'd3, 32'h40000000, 32'h02011403, 32'd0},
        {4'd5,  2'd2, 32'h8007FF01, 32'h00000000, 32'd53789},
        {4'd11, 2'd3, 32'hC0000000, 32'hFF01FF01, 32'd1755675000}
    };

    pll_freq_calc dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .src_sel_i  (src_sel_i),
        .ctrl_i     (ctrl_i),
        .coef_i     (coef_i),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .freq_khz_o (freq_khz_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles >= WD_LIMIT) begin
            tests = tests + 1;
            fails = fails + 1;
            $display("FAIL watchdog: got %0d cycles expected < %0d", cycles, WD_LIMIT);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    function automatic string tag_name(input logic [3:0] id);
        case (id)
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd7:    return "R7";
            4'd8:    return "R8";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests = tests + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic launch(input logic [1:0] s, input logic [31:0] c, input logic [31:0] k);
        @(negedge clk);
        src_sel_i = s;
        ctrl_i    = c;
        coef_i    = k;
        start_i   = 1'b1;
        @(negedge clk);
        start_i   = 1'b0;
    endtask

    task automatic wait_done();
        for (int n = 0; n < 400 && !done_o; n++) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", {29'd0, busy_o, done_o, 1'b0}, 32'd0);
        check("R1", freq_khz_o, 32'd0);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            launch(VEC[i][97:96], VEC[i][95:64], VEC[i][63:32]);
            wait_done();
            check("R9", {31'd0, done_o & ~busy_o}, 32'd1);
            check(tag_name(VEC[i][101:98]), freq_khz_o, VEC[i][31:0]);
        end

        // R10: start while busy is ignored
        launch(2'd2, 32'h80000A01, 32'd0);
        repeat (5) @(negedge clk);
        src_sel_i = 2'd3; ctrl_i = 32'hC0000000; coef_i = 32'h02011403; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done();
        check("R10", freq_khz_o, 32'd270000);
        repeat (120) @(negedge clk);
        check("R10", {30'd0, busy_o, done_o}, 32'd0);
        check("R10", freq_khz_o, 32'd270000);

        // R10: start taken in the done cycle; old value held until next strobe
        launch(2'd2, 32'h80026403, 32'd0);
        wait_done();
        check("R5", freq_khz_o, 32'd225000);
        src_sel_i = 2'd3; ctrl_i = 32'hC0000000; coef_i = 32'h02011403; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R10", {31'd0, busy_o}, 32'd1);
        check("R9", freq_khz_o, 32'd225000);
        wait_done();
        check("R10", freq_khz_o, 32'd360000);

        // R1: reset mid-run clears outputs
        launch(2'd2, 32'h80000A01, 32'd0);
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1", {30'd0, busy_o, done_o}, 32'd0);
        check("R1", freq_khz_o, 32'd0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule